// File: doc/BRIEF.md
# Strided Vector Memory Access Unit

This block carries out one vector memory command at a time against a word-interleaved memory of several banks. A command gives a starting word address, a stride and an element count. The unit produces one element address per cycle. Each address is the previous one plus the stride. The unit sends each address to the bank chosen by the low address bits. A bank is a fixed-latency access stage that stays occupied for the whole access. When the next element maps to a bank that is still occupied, the unit holds that element until the bank becomes free.

For a load, each returning word is written into the on-block vector register at the element position carried with its request. For a store, the unit takes the word for element i from the vector register and sends it to the i-th address. The surrounding datapath fills and reads the vector register through a plain write port and a plain read port while the unit is idle. A one-cycle done strobe marks the end of each command.

The element rate depends on the stride. A stride that shares no factor with the bank count keeps every bank's accesses far enough apart to allow one element per cycle. Other strides send elements back to the same bank sooner than the bank latency allows, and the unit stalls.

Top module: `vec_stride_agu`

## Requirements
- R1: After reset, busy and done are low.
- R2: Element i of a command uses word address (base + i*stride) modulo 2^AW. The stride is taken as a two's-complement value, so 0xFF steps the address down by one.
- R3: The bank is address bits [3:0] and the row inside the bank is address bits [7:4]. Words in different rows of the same bank are stored separately.
- R4: With an odd stride, element i is accepted by its bank i+1 cycles after the command edge. A load of n elements therefore pulses done n+11 cycles after the command edge, and a store of n elements pulses done n cycles after it.
- R5: A bank accepts a new access only 11 or more cycles after its previous one, and at most one bank accepts an access in any cycle.
- R6: With an even stride, element i issues at the later of (issue of element i-1 plus one cycle) and (its bank's previous accept plus 11 cycles). Done timing follows that schedule.
- R7: A loaded word is written to register element i for request i, and at most one bank returns a word in any cycle.
- R8: A store writes register element i to the address of element i. A later load returns that word.
- R9: Any length from 0 to 16 elements is accepted. A length of 0 touches neither memory nor the register, and done pulses in the cycle after the command edge.
- R10: done is high for exactly one cycle. For a load it follows the last register write. For a store it follows the last bank accept.
- R11: cmd_valid is ignored while busy is high. The running command keeps its timing and the memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a command (taken only while idle) |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | AW | First word address |
| cmd_stride | input | AW | Address step, two's complement |
| cmd_vlen | input | VLW | Element count, 0 to VLMAX |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command strobe |
| vrf_wr_en | input | 1 | Vector register write from outside |
| vrf_wr_idx | input | EIW | Element index to write |
| vrf_wr_data | input | DW | Word to write |
| vrf_rd_idx | input | EIW | Element index to read |
| vrf_rd_data | output | DW | Word at vrf_rd_idx (combinational) |

## Verification
The assertions assume a command length no larger than VLMAX. They also assume that the vector register is written from outside only while the unit is idle, and that no new command arrives in the cycle done is high. Without that last condition, a zero-length command could raise done twice in a row. The bench keeps within these limits. It waits one idle cycle after every done before driving the next command, writes the register only between commands, and never asks for more than 16 elements. It presents a command while busy only in the one scenario that checks that such a command is ignored.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic {AG_IDLE = 1'b0, AG_RUN = 1'b1} ag_state_e;
endpackage

// File: rtl/vsa_bank.sv
module vsa_bank #(
  parameter int DW  = 16,
  parameter int RW  = 4,
  parameter int EIW = 4,
  parameter int LAT = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  logic           we,
  input  logic [RW-1:0]  row,
  input  logic [DW-1:0]  wdata,
  input  logic [EIW-1:0] tag,
  output logic           ready,
  output logic           rsp_vld,
  output logic [DW-1:0]  rsp_data,
  output logic [EIW-1:0] rsp_tag
);
  localparam int CW   = $clog2(LAT);
  localparam int ROWS = 1 << RW;

  logic [CW-1:0]  cnt_q, cnt_n;
  logic           we_q;
  logic [RW-1:0]  row_q;
  logic [DW-1:0]  wd_q;
  logic [EIW-1:0] tag_q;
  logic [DW-1:0]  mem [ROWS];
  logic           fin;

  assign ready = (cnt_q == '0);
  assign fin   = (cnt_q == CW'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (acc)               cnt_n = CW'(LAT - 1);
    else if (cnt_q != '0)  cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rsp_vld <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      rsp_vld <= fin && !we_q;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      we_q  <= we;
      row_q <= row;
      wd_q  <= wdata;
      tag_q <= tag;
    end
    if (fin && we_q) mem[row_q] <= wd_q;
    if (fin && !we_q) begin
      rsp_data <= mem[row_q];
      rsp_tag  <= tag_q;
    end
  end
endmodule

// File: rtl/vsa_agen.sv
module vsa_agen import vsa_pkg::*; #(
  parameter int AW    = 8,
  parameter int NBANK = 16,
  parameter int VLW   = 5,
  parameter int EIW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_store,
  input  logic [AW-1:0]    cmd_base,
  input  logic [AW-1:0]    cmd_stride,
  input  logic [VLW-1:0]   cmd_vlen,
  input  logic [NBANK-1:0] bank_ready,
  input  logic             wb_valid,
  output logic             iss_valid,
  output logic             iss_we,
  output logic [AW-1:0]    iss_addr,
  output logic [EIW-1:0]   iss_idx,
  output logic [AW-1:0]    cur_stride,
  output logic             busy,
  output logic             done
);
  localparam int BW = $clog2(NBANK);

  ag_state_e      st_q, st_n;
  logic           store_q, store_n, done_n, data_en;
  logic [AW-1:0]  addr_q, addr_n, stride_q, stride_n;
  logic [VLW-1:0] vlen_q, vlen_n, iss_q, iss_n, wb_q, wb_n;
  logic           start;

  assign start      = (st_q == AG_IDLE) && cmd_valid;
  assign iss_valid  = (st_q == AG_RUN) && (iss_q < vlen_q) && bank_ready[addr_q[BW-1:0]];
  assign iss_we     = store_q;
  assign iss_addr   = addr_q;
  assign iss_idx    = iss_q[EIW-1:0];
  assign cur_stride = stride_q;
  assign busy       = (st_q == AG_RUN);
  assign data_en    = start || iss_valid;

  always_comb begin
    st_n     = st_q;
    store_n  = store_q;
    addr_n   = addr_q;
    stride_n = stride_q;
    vlen_n   = vlen_q;
    iss_n    = iss_q;
    wb_n     = wb_q;
    done_n   = 1'b0;
    if (start) begin
      if (cmd_vlen == '0) begin
        done_n = 1'b1;
      end else begin
        st_n     = AG_RUN;
        store_n  = cmd_store;
        addr_n   = cmd_base;
        stride_n = cmd_stride;
        vlen_n   = cmd_vlen;
        iss_n    = '0;
        wb_n     = '0;
      end
    end else if (st_q == AG_RUN) begin
      if (iss_valid) begin
        addr_n = addr_q + stride_q;
        iss_n  = iss_q + VLW'(1);
        if (store_q && (iss_q == vlen_q - VLW'(1))) begin
          done_n = 1'b1;
          st_n   = AG_IDLE;
        end
      end
      if (!store_q && wb_valid) begin
        wb_n = wb_q + VLW'(1);
        if (wb_q == vlen_q - VLW'(1)) begin
          done_n = 1'b1;
          st_n   = AG_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= AG_IDLE;
      done <= 1'b0;
      iss_q <= '0;
      wb_q  <= '0;
    end else begin
      st_q <= st_n;
      done <= done_n;
      iss_q <= iss_n;
      wb_q  <= wb_n;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      store_q  <= store_n;
      addr_q   <= addr_n;
      stride_q <= stride_n;
      vlen_q   <= vlen_n;
    end
  end
endmodule

// File: rtl/vsa_vrf.sv
module vsa_vrf #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int EIW   = 4
) (
  input  logic           clk,
  input  logic           we,
  input  logic [EIW-1:0] widx,
  input  logic [DW-1:0]  wdata,
  input  logic [EIW-1:0] ridx_a,
  output logic [DW-1:0]  rdata_a,
  input  logic [EIW-1:0] ridx_b,
  output logic [DW-1:0]  rdata_b
);
  logic [DW-1:0] regs [DEPTH];

  assign rdata_a = regs[ridx_a];
  assign rdata_b = regs[ridx_b];

  always_ff @(posedge clk) begin
    if (we) regs[widx] <= wdata;
  end
endmodule

// File: rtl/vec_stride_agu.sv
module vec_stride_agu #(
  parameter  int DW    = 16,
  parameter  int AW    = 8,
  parameter  int NBANK = 16,
  parameter  int LAT   = 11,
  parameter  int VLMAX = 16,
  localparam int VLW   = $clog2(VLMAX + 1),
  localparam int EIW   = $clog2(VLMAX)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic           cmd_store,
  input  logic [AW-1:0]  cmd_base,
  input  logic [AW-1:0]  cmd_stride,
  input  logic [VLW-1:0] cmd_vlen,
  output logic           busy,
  output logic           done,
  input  logic           vrf_wr_en,
  input  logic [EIW-1:0] vrf_wr_idx,
  input  logic [DW-1:0]  vrf_wr_data,
  input  logic [EIW-1:0] vrf_rd_idx,
  output logic [DW-1:0]  vrf_rd_data
);
  localparam int BW = $clog2(NBANK);
  localparam int RW = AW - BW;

  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_m} <= 2'b00;
    else        {rst_q, rst_m} <= {rst_m, 1'b1};
  end

  logic             iss_valid, iss_we, wb_valid;
  logic [AW-1:0]    iss_addr, cur_stride;
  logic [EIW-1:0]   iss_idx, wb_tag;
  logic [DW-1:0]    st_data, wb_data;
  logic [NBANK-1:0] bank_rdy, bank_acc, rsp_vld;
  logic [DW-1:0]    rsp_dat [NBANK];
  logic [EIW-1:0]   rsp_tag [NBANK];

  vsa_agen #(.AW(AW), .NBANK(NBANK), .VLW(VLW), .EIW(EIW)) agen_i (
    .clk(clk), .rst_n(rst_q),
    .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_base(cmd_base),
    .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen),
    .bank_ready(bank_rdy), .wb_valid(wb_valid),
    .iss_valid(iss_valid), .iss_we(iss_we), .iss_addr(iss_addr),
    .iss_idx(iss_idx), .cur_stride(cur_stride), .busy(busy), .done(done)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_acc[b] = iss_valid && (iss_addr[BW-1:0] == BW'(b));
    vsa_bank #(.DW(DW), .RW(RW), .EIW(EIW), .LAT(LAT)) bank_i (
      .clk(clk), .rst_n(rst_q),
      .acc(bank_acc[b]), .we(iss_we), .row(iss_addr[AW-1:BW]),
      .wdata(st_data), .tag(iss_idx),
      .ready(bank_rdy[b]), .rsp_vld(rsp_vld[b]),
      .rsp_data(rsp_dat[b]), .rsp_tag(rsp_tag[b])
    );
  end

  always_comb begin
    wb_valid = |rsp_vld;
    wb_data  = '0;
    wb_tag   = '0;
    for (int b = 0; b < NBANK; b++) begin
      wb_data = wb_data | (rsp_dat[b] & {DW{rsp_vld[b]}});
      wb_tag  = wb_tag  | (rsp_tag[b] & {EIW{rsp_vld[b]}});
    end
  end

  vsa_vrf #(.DW(DW), .DEPTH(VLMAX), .EIW(EIW)) vrf_i (
    .clk(clk),
    .we(wb_valid || vrf_wr_en),
    .widx(wb_valid ? wb_tag : vrf_wr_idx),
    .wdata(wb_valid ? wb_data : vrf_wr_data),
    .ridx_a(iss_idx), .rdata_a(st_data),
    .ridx_b(vrf_rd_idx), .rdata_b(vrf_rd_data)
  );
endmodule

// File: rtl/vec_stride_agu_chk.sv
module vec_stride_agu_chk #(
  parameter int NBANK = 16,
  parameter int LAT   = 11,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] bank_acc,
  input logic [NBANK-1:0] rsp_vld,
  input logic             busy,
  input logic             done,
  input logic             iss_valid,
  input logic [AW-1:0]    iss_addr,
  input logic [AW-1:0]    cur_stride
);
  localparam int GW = $clog2(LAT + 1);

  assert_one_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_acc));

  assert_one_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_vld));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bank_acc == '0));

  logic          li_valid;
  logic [AW-1:0] li_addr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) li_valid <= 1'b0;
    else        li_valid <= iss_valid ? 1'b1 : (busy ? li_valid : 1'b0);
  end
  always_ff @(posedge clk) begin
    if (iss_valid) li_addr <= iss_addr;
  end

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && li_valid) |-> (iss_addr == AW'(li_addr + cur_stride)));

  for (genvar b = 0; b < NBANK; b++) begin : g_gap
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 gap_q <= GW'(LAT);
      else if (bank_acc[b])       gap_q <= '0;
      else if (gap_q < GW'(LAT))  gap_q <= gap_q + GW'(1);
    end
    assert_bank_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bank_acc[b] |-> (gap_q >= GW'(LAT - 1)));
  end
endmodule

bind vec_stride_agu vec_stride_agu_chk #(.NBANK(NBANK), .LAT(LAT), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_q), .bank_acc(bank_acc), .rsp_vld(rsp_vld),
  .busy(busy), .done(done), .iss_valid(iss_valid), .iss_addr(iss_addr),
  .cur_stride(cur_stride)
);

// File: tb/vec_stride_agu_tb_top.sv
module vec_stride_agu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 11;

  logic        clk, rst_n, cmd_valid, cmd_store, busy, done;
  logic [7:0]  cmd_base, cmd_stride;
  logic [4:0]  cmd_vlen;
  logic        vrf_wr_en;
  logic [3:0]  vrf_wr_idx, vrf_rd_idx;
  logic [15:0] vrf_wr_data, vrf_rd_data;

  vec_stride_agu dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen),
    .busy(busy), .done(done), .vrf_wr_en(vrf_wr_en), .vrf_wr_idx(vrf_wr_idx),
    .vrf_wr_data(vrf_wr_data), .vrf_rd_idx(vrf_rd_idx), .vrf_rd_data(vrf_rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int edge_no = 0;
  always @(posedge clk) edge_no <= edge_no + 1;

  int n_chk = 0, n_bad = 0;
  logic [15:0] mem_m [256];
  bit          mem_k [256];
  logic [15:0] vrf_m [16];
  bit          vrf_k [16];
  int          bank_free [16];

  function automatic void chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endfunction

  // bench schedule: returns edges from command edge to done
  function automatic int sched(bit st, int base, int stride, int vlen, int c0);
    int prev = c0;
    for (int i = 0; i < vlen; i++) begin
      int a = (base + i * stride) & 255;
      int b = a & 15;
      int t = prev + 1;
      if (bank_free[b] > t) t = bank_free[b];
      bank_free[b] = t + LAT;
      prev = t;
      if (st) begin
        mem_m[a] = vrf_m[i]; mem_k[a] = vrf_k[i];
      end else begin
        vrf_m[i] = mem_m[a]; vrf_k[i] = mem_k[a];
      end
    end
    if (vlen == 0) return 0;
    return st ? (prev - c0) : (prev + LAT - c0);
  endfunction

  task automatic start_cmd(bit st, int base, int stride, int vlen, output int c0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_store = st;
    cmd_base = 8'(base); cmd_stride = 8'(stride); cmd_vlen = 5'(vlen);
    @(posedge clk); #1;
    c0 = edge_no;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(int c0, output int got);
    int n = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      n++;
      if (n > 3000) begin chk(0, "watchdog", n, 0); break; end
    end
    got = edge_no - c0;
  endtask

  task automatic run_cmd(bit st, int base, int stride, int vlen, string req);
    int c0, d, got;
    start_cmd(st, base, stride, vlen, c0);
    d = sched(st, base, stride, vlen, c0);
    wait_done(c0, got);
    chk(got == d, req, got, d);
    @(negedge clk);
    chk(done == 1'b0, {req, " R10 pulse"}, done, 0);
  endtask

  task automatic fill_vrf(int seed);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      vrf_wr_en = 1'b1; vrf_wr_idx = 4'(i);
      vrf_wr_data = 16'(seed * 977 + i * 131 + 5);
      vrf_m[i] = vrf_wr_data; vrf_k[i] = 1'b1;
    end
    @(negedge clk);
    vrf_wr_en = 1'b0;
  endtask

  task automatic check_vrf(string req);
    for (int i = 0; i < 16; i++) begin
      if (vrf_k[i]) begin
        @(negedge clk);
        vrf_rd_idx = 4'(i);
        #1;
        chk(vrf_rd_data == vrf_m[i], req, vrf_rd_data, vrf_m[i]);
      end
    end
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
  endtask

  task automatic t_unit_stride;
    fill_vrf(1);
    run_cmd(1, 0, 1, 16, "R4 R8 store stride 1");
    fill_vrf(2);
    run_cmd(0, 0, 1, 16, "R4 load stride 1");
    check_vrf("R7 R8 load data stride 1");
  endtask

  task automatic t_same_bank;
    fill_vrf(3);
    run_cmd(1, 3, 16, 8, "R5 store stride 16");
    fill_vrf(4);
    run_cmd(0, 3, 16, 8, "R5 load stride 16");
    check_vrf("R3 rows of one bank");
  endtask

  task automatic t_odd_stride;
    fill_vrf(5);
    run_cmd(1, 8'h40, 3, 16, "R4 store stride 3");
    fill_vrf(6);
    run_cmd(0, 8'h40, 3, 16, "R4 load stride 3");
    check_vrf("R2 R7 data stride 3");
  endtask

  task automatic t_even_stride;
    fill_vrf(7);
    run_cmd(0, 0, 2, 16, "R6 load stride 2");
    check_vrf("R6 data stride 2");
    run_cmd(0, 8'h40, 4, 12, "R6 load stride 4");
    check_vrf("R6 data stride 4");
    run_cmd(0, 1, 8, 10, "R6 load stride 8");
    check_vrf("R6 data stride 8");
  endtask

  task automatic t_wrap;
    fill_vrf(8);
    run_cmd(1, 8'hF8, 5, 16, "R2 store wrap stride 5");
    fill_vrf(11);
    run_cmd(0, 8'hF8, 5, 16, "R2 load wrap stride 5");
    check_vrf("R2 wrap data");
    run_cmd(0, 8'h0F, 8'hFF, 16, "R2 load stride -1");
    check_vrf("R2 descending data");
  endtask

  task automatic t_short;
    fill_vrf(12);
    run_cmd(0, 0, 1, 0, "R9 zero length");
    check_vrf("R9 register untouched");
    run_cmd(0, 5, 9, 1, "R9 one element");
    check_vrf("R9 one element data");
  endtask

  task automatic t_busy_cmd;
    int c0, d, got;
    fill_vrf(9);
    run_cmd(1, 8'h80, 1, 4, "R11 prepare");
    fill_vrf(10);
    start_cmd(0, 3, 16, 8, c0);
    d = sched(0, 3, 16, 8, c0);
    repeat (2) @(negedge clk);
    cmd_valid = 1'b1; cmd_store = 1'b1;
    cmd_base = 8'h80; cmd_stride = 8'h01; cmd_vlen = 5'd4;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    wait_done(c0, got);
    chk(got == d, "R11 timing kept", got, d);
    @(negedge clk);
    check_vrf("R11 running load data");
    run_cmd(0, 8'h80, 1, 4, "R11 readback");
    check_vrf("R11 memory unchanged");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem_m[i] = '0; mem_k[i] = 1'b0; end
    for (int i = 0; i < 16; i++) begin
      vrf_m[i] = '0; vrf_k[i] = 1'b0; bank_free[i] = 0;
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0;
    cmd_base = '0; cmd_stride = '0; cmd_vlen = '0;
    vrf_wr_en = 1'b0; vrf_wr_idx = '0; vrf_wr_data = '0; vrf_rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_unit_stride;
    t_same_bank;
    t_odd_stride;
    t_even_stride;
    t_wrap;
    t_short;
    t_busy_cmd;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", edge_no);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule